// File: doc/BRIEF.md
# Line Diagnostic Filter Unit

This block condenses a stream of line-measurement samples into three running statistics: the largest unsigned magnitude seen, a low-pass DC average and a low-pass level of the rectified signal (the AC level). The six candidate streams are tip voltage, ring voltage, loop voltage, longitudinal voltage, loop current and longitudinal current. They arrive as 16-bit two's complement values that share one single-cycle valid strobe. A select input picks the stream that feeds all three paths.

A small register port lets a host turn the unit on and set the two filter coefficients. The host reads the three results and can load or clear the peak register. Each filter has a 32-bit state that carries 16 fractional bits. Enabling the unit or switching the source clears all state, so every measurement starts from zero. A later write of zero to the peak register starts a new peak interval. The host uses the results to work out resistance and impedance.

Top module: `line_diag_filter`

## Requirements
- R1: `src_sel` codes are 0 tip voltage, 1 ring voltage, 2 loop voltage, 3 longitudinal voltage, 4 loop current and 5 longitudinal current. Codes 6 and 7 feed a sample of zero.
- R2: Register addresses are 0 control (bit 0 is the enable and reads back), 1 DC coefficient, 2 AC coefficient, 3 DC result (read only), 4 AC result (read only) and 5 peak (read and write). Addresses 6 and 7 read as zero. Writes to 3, 4, 6 and 7 have no effect. Reads are combinational and written values show on the next cycle.
- R3: On each valid sample while enabled, the peak becomes the larger of itself and the sample magnitude, compared as unsigned values.
- R4: The magnitude of -32768 saturates to 32767 in both the peak path and the AC path.
- R5: The DC state `a` is a signed 32-bit value with 16 fractional bits. On each valid sample `x` while enabled it becomes `a + floor(k*(x*65536 - a)/65536)`, with `k` the DC coefficient. The DC result is `floor(a/65536)` in 16 bits.
- R6: The AC state follows the R5 rule on the sample magnitude, using the AC coefficient. It is never negative.
- R7: A control write that sets the enable while it is clear zeroes the peak and both filter states at that edge. A sample in the same cycle is dropped.
- R8: While enabled, a change of `src_sel` from its value in the previous cycle zeroes the peak and both filter states. The sample of that cycle is dropped.
- R9: A peak write loads the written value, so a zero restarts capture. It wins over a sample in the same cycle, and a flush from R7 or R8 wins over it.
- R10: While disabled, samples and source changes leave all three results unchanged.
- R11: After reset, every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Single-cycle strobe: all six samples are valid |
| v_tip | input | 16 | Tip voltage sample |
| v_ring | input | 16 | Ring voltage sample |
| v_loop | input | 16 | Loop voltage sample |
| v_long | input | 16 | Longitudinal voltage sample |
| i_loop | input | 16 | Loop current sample |
| i_long | input | 16 | Longitudinal current sample |
| src_sel | input | 3 | Source select |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
The main pass drives four kinds of input, each through every source and with different coefficients:
- Full-range random samples exercise the floor rounding of negative filter steps.
- Alternating large positive and negative samples make the DC and AC results diverge and catch a missing or misplaced rectifier.
- Constant samples show whether the filter converges toward the sample or drifts from truncation.
- Ramps make the peak rise step by step, exposing a comparison that is signed where it should be unsigned.

Coefficients of 0 and 0xFFFF mark the frozen and near-instant extremes of the filter. Directed cases cover the following:
- -32768 at the input.
- A peak write that lands in the same cycle as a sample.
- A source switch while enabled.
- A source switch while disabled.

// File: rtl/line_diag_filter.sv
module line_diag_filter #(
  parameter int DW = 16,
  parameter int KW = 16,
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] v_tip,
  input  logic signed [DW-1:0] v_ring,
  input  logic signed [DW-1:0] v_loop,
  input  logic signed [DW-1:0] v_long,
  input  logic signed [DW-1:0] i_loop,
  input  logic signed [DW-1:0] i_long,
  input  logic [2:0]           src_sel,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata
);
  localparam int ACW = DW + KW;
  localparam int DFW = ACW + 2;
  localparam int PW  = DFW + KW + 1;
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_DK  = AW'(1);
  localparam logic [AW-1:0] A_AK  = AW'(2);
  localparam logic [AW-1:0] A_DC  = AW'(3);
  localparam logic [AW-1:0] A_AC  = AW'(4);
  localparam logic [AW-1:0] A_PK  = AW'(5);
  localparam logic [DW-1:0] SMIN  = {1'b1, {(DW-1){1'b0}}};

  logic                  en_q;
  logic [2:0]            src_q;
  logic [KW-1:0]         dk_q, ak_q;
  logic signed [ACW-1:0] dc_acc, ac_acc;
  logic [DW-1:0]         pk_q;
  logic signed [DW-1:0]  x;
  logic [DW-1:0]         x_abs;

  always_comb begin
    case (src_sel)
      3'd0:    x = v_tip;
      3'd1:    x = v_ring;
      3'd2:    x = v_loop;
      3'd3:    x = v_long;
      3'd4:    x = i_loop;
      3'd5:    x = i_long;
      default: x = '0;
    endcase
  end

  assign x_abs = (x == SMIN) ? ~SMIN : (x[DW-1] ? -x : x);

  function automatic logic signed [ACW-1:0] iir_step(
    input logic signed [ACW-1:0] acc,
    input logic signed [DW-1:0]  s,
    input logic [KW-1:0]         k
  );
    logic signed [DFW-1:0] d;
    logic signed [PW-1:0]  p;
    d = {{2{s[DW-1]}}, s, {KW{1'b0}}} - {{2{acc[ACW-1]}}, acc};
    p = $signed({1'b0, k}) * d;
    return ACW'(acc + (p >>> KW));
  endfunction

  wire wr_ctl  = reg_wr && (reg_addr == A_CTL);
  wire en_rise = wr_ctl && reg_wdata[0] && !en_q;
  wire src_chg = en_q && (src_sel != src_q);
  wire flush   = en_rise || src_chg;
  wire pk_wr   = reg_wr && (reg_addr == A_PK);
  wire upd     = en_q && smp_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      src_q  <= '0;
      dk_q   <= '0;
      ak_q   <= '0;
      dc_acc <= '0;
      ac_acc <= '0;
      pk_q   <= '0;
    end else begin
      src_q <= src_sel;
      if (wr_ctl) en_q <= reg_wdata[0];
      if (reg_wr && reg_addr == A_DK) dk_q <= reg_wdata[KW-1:0];
      if (reg_wr && reg_addr == A_AK) ak_q <= reg_wdata[KW-1:0];
      if (flush) begin
        dc_acc <= '0;
        ac_acc <= '0;
        pk_q   <= '0;
      end else begin
        if (upd) begin
          dc_acc <= iir_step(dc_acc, x, dk_q);
          ac_acc <= iir_step(ac_acc, $signed(x_abs), ak_q);
        end
        if (pk_wr) pk_q <= reg_wdata;
        else if (upd && x_abs > pk_q) pk_q <= x_abs;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {{(DW-1){1'b0}}, en_q};
      A_DK:    reg_rdata = DW'(dk_q);
      A_AK:    reg_rdata = DW'(ak_q);
      A_DC:    reg_rdata = dc_acc[ACW-1:KW];
      A_AC:    reg_rdata = ac_acc[ACW-1:KW];
      A_PK:    reg_rdata = pk_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/line_diag_filter_chk.sv
module line_diag_filter_chk #(
  parameter int DW = 16,
  parameter int KW = 16,
  parameter int AW = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en_q,
  input logic [2:0]              src_q,
  input logic [2:0]              src_sel,
  input logic                    reg_wr,
  input logic [AW-1:0]           reg_addr,
  input logic [DW-1:0]           reg_wdata,
  input logic signed [DW+KW-1:0] dc_acc,
  input logic signed [DW+KW-1:0] ac_acc,
  input logic [DW-1:0]           pk_q
);
  assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_wr) |=> ($stable(dc_acc) && $stable(ac_acc) && $stable(pk_q)));

  assert_rise_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(0) && reg_wdata[0] && !en_q)
      |=> (dc_acc == '0 && ac_acc == '0 && pk_q == '0));

  assert_src_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && src_sel != src_q) |=> (dc_acc == '0 && ac_acc == '0 && pk_q == '0));

  assert_pk_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(5) && reg_wdata == '0) |=> (pk_q == '0));

  assert_pk_rising_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && src_sel == src_q && !reg_wr) |=> (pk_q >= $past(pk_q)));

  assert_ac_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_acc[DW+KW-1]);
endmodule

bind line_diag_filter line_diag_filter_chk #(.DW(DW), .KW(KW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .src_q(src_q), .src_sel(src_sel),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .dc_acc(dc_acc), .ac_acc(ac_acc), .pk_q(pk_q)
);

// File: tb/sim_line_diag_filter.sv
`timescale 1ns/1ps
module sim_line_diag_filter;
  logic clk = 0, rst_n = 0, smp_vld = 0, reg_wr = 0;
  logic signed [15:0] v_tip = 0, v_ring = 0, v_loop = 0, v_long = 0, i_loop = 0, i_long = 0;
  logic [2:0] src_sel = 0, reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  int checks = 0, errors = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  line_diag_filter u0 (.*);

  // behavioural reference
  bit m_en; int m_src, m_dk, m_ak, m_pk; longint m_dc, m_ac;

  function automatic int pick(int s);
    case (s)
      0: return int'(v_tip);  1: return int'(v_ring);
      2: return int'(v_loop); 3: return int'(v_long);
      4: return int'(i_loop); 5: return int'(i_long);
      default: return 0;
    endcase
  endfunction

  function automatic int mag(int v);
    if (v == -32768) return 32767;
    return (v < 0) ? -v : v;
  endfunction

  function automatic longint filt(longint a, int x, int k);
    longint d = longint'(x) * 65536 - a;
    longint p = longint'(k) * d;
    return a + (p >>> 16);
  endfunction

  always @(posedge clk) begin
    int x, ax, np; bit fl, up; longint nd, na;
    if (!rst_n) begin
      m_en = 0; m_src = 0; m_dk = 0; m_ak = 0; m_pk = 0; m_dc = 0; m_ac = 0;
    end else begin
      x  = pick(int'(src_sel)); ax = mag(x);
      fl = (reg_wr && reg_addr == 0 && reg_wdata[0] && !m_en) || (m_en && int'(src_sel) != m_src);
      up = m_en && smp_vld;
      nd = m_dc; na = m_ac; np = m_pk;
      if (fl) begin nd = 0; na = 0; np = 0; end
      else begin
        if (up) begin nd = filt(m_dc, x, m_dk); na = filt(m_ac, ax, m_ak); end
        if (reg_wr && reg_addr == 5) np = int'(reg_wdata);
        else if (up && ax > np) np = ax;
      end
      if (reg_wr && reg_addr == 0) m_en = reg_wdata[0];
      if (reg_wr && reg_addr == 1) m_dk = int'(reg_wdata);
      if (reg_wr && reg_addr == 2) m_ak = int'(reg_wdata);
      m_dc = nd; m_ac = na; m_pk = np; m_src = int'(src_sel);
    end
  end

  function automatic int expect_rd(int a);
    case (a)
      0: return int'(m_en);
      1: return m_dk;
      2: return m_ak;
      3: return int'(m_dc >>> 16) & 16'hFFFF;
      4: return int'(m_ac >>> 16) & 16'hFFFF;
      5: return m_pk & 16'hFFFF;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    int e; string tag;
    if (rst_n && !done) begin
      e = expect_rd(int'(reg_addr));
      case (reg_addr)
        3: tag = "R5 dc"; 4: tag = "R6 ac"; 5: tag = "R3 peak"; default: tag = "R2 reg";
      endcase
      chk(int'(reg_rdata) == e, tag, int'(reg_rdata), e);
    end
  end

  task automatic cyc(bit vld, logic [2:0] s, bit wr, logic [2:0] a, logic [15:0] wd);
    @(posedge clk); #2;
    smp_vld = vld; src_sel = s; reg_wr = wr; reg_addr = a; reg_wdata = wd;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    cyc(0, src_sel, 0, a, 0);
    @(negedge clk); v = int'(reg_rdata);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] wd);
    cyc(0, src_sel, 1, a, wd);
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return int'(seed >> 8);
  endfunction

  task automatic set_all(int v);
    v_tip = 16'(v); v_ring = 16'(v); v_loop = 16'(v); v_long = 16'(v); i_loop = 16'(v); i_long = 16'(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, a0, a1, a2;
    repeat (3) @(posedge clk); #2 rst_n = 1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk(v == 0, "R11 reset", v, 0);
    end

    // directed filter values
    wr(1, 16'h8000); wr(2, 16'h4000); wr(0, 1);
    set_all(0); v_tip = 1000;
    cyc(1, 0, 0, 3, 0);
    rd(3, v); chk(v == 500, "R5 first step", v, 500);
    rd(4, v); chk(v == 250, "R6 first step", v, 250);
    rd(5, v); chk(v == 1000, "R3 peak", v, 1000);
    v_tip = -16'sd32768;
    cyc(1, 0, 0, 5, 0);
    rd(5, v); chk(v == 32767, "R4 saturation", v, 32767);

    // streamed patterns against the model
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: begin wr(1, 16'h0100); wr(2, 16'h2000); end
        1: begin wr(1, 16'hFFFF); wr(2, 16'h0000); end
        2: begin wr(1, 16'h0040); wr(2, 16'hFFFF); end
        default: begin wr(1, 16'h7000); wr(2, 16'h0800); end
      endcase
      for (int s = 0; s < 6; s++) begin
        for (int i = 0; i < 60; i++) begin
          case (p)
            0: begin v_tip = 16'(rnd()); v_ring = 16'(rnd()); v_loop = 16'(rnd());
                      v_long = 16'(rnd()); i_loop = 16'(rnd()); i_long = 16'(rnd()); end
            1: set_all((i % 2) ? -30000 + s * 100 : 29000 - s * 50);
            2: set_all(-1234 - s * 7);
            default: set_all(i * 500 - 12000 + s);
          endcase
          if (i == 59) v_tip = -16'sd32768;
          cyc((rnd() % 4) != 0, 3'(s), 0, 3'(3 + (i % 3)), 0);
        end
      end
    end

    // R9 peak write semantics
    wr(1, 16'h8000);
    set_all(20000);
    cyc(1, src_sel, 1, 5, 0);
    rd(5, v); chk(v == 0, "R9 zero write wins over sample", v, 0);
    set_all(500); cyc(1, src_sel, 0, 5, 0);
    rd(5, v); chk(v == 500, "R9 restart capture", v, 500);
    wr(5, 700); set_all(600); cyc(1, src_sel, 0, 5, 0);
    rd(5, v); chk(v == 700, "R9 loaded value", v, 700);

    // R8 source change flushes and drops the sample
    set_all(9000); cyc(1, 3'd1, 0, 5, 0);
    rd(5, v); chk(v == 0, "R8 peak flushed", v, 0);
    rd(3, v); chk(v == 0, "R8 dc flushed", v, 0);

    // R1 source codes
    set_all(30000); i_loop = -1234;
    cyc(0, 3'd4, 0, 5, 0);
    cyc(1, 3'd4, 0, 5, 0);
    rd(5, v); chk(v == 1234, "R1 loop current picked", v, 1234);
    cyc(0, 3'd6, 0, 5, 0);
    cyc(1, 3'd6, 0, 5, 0);
    rd(5, v); chk(v == 0, "R1 code 6 is zero", v, 0);
    cyc(0, 3'd3, 0, 5, 0);
    v_long = -8000;
    cyc(1, 3'd3, 0, 5, 0);
    rd(5, v); chk(v == 8000, "R1 longitudinal voltage", v, 8000);

    // R2 register map
    rd(3, a0); wr(3, 16'h1234); rd(3, v); chk(v == a0, "R2 dc read only", v, a0);
    rd(1, v); chk(v == 16'h8000, "R2 coefficient readback", v, 16'h8000);
    wr(7, 16'hFFFF); rd(7, v); chk(v == 0, "R2 addr 7 reads zero", v, 0);

    // R10 disabled holds
    wr(0, 0);
    rd(3, a0); rd(4, a1); rd(5, a2);
    set_all(25000);
    cyc(1, 3'd3, 0, 3, 0);
    cyc(1, 3'd0, 0, 4, 0);
    cyc(1, 3'd2, 0, 5, 0);
    rd(3, v); chk(v == a0, "R10 dc held", v, a0);
    rd(4, v); chk(v == a1, "R10 ac held", v, a1);
    rd(5, v); chk(v == a2, "R10 peak held", v, a2);

    // R7 enable rising edge flush, same-cycle sample dropped
    smp_vld = 1;
    cyc(1, 3'd2, 1, 0, 1);
    rd(5, v); chk(v == 0, "R7 peak flushed", v, 0);
    rd(3, v); chk(v == 0, "R7 dc flushed", v, 0);
    rd(4, v); chk(v == 0, "R7 ac flushed", v, 0);

    cyc(0, src_sel, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule